// File: doc/BRIEF.md
# CNF Clause Gain Evaluator

This block holds a Boolean formula in conjunctive normal form as a bank of clause slots and, for a given variable assignment, works out how flipping each variable would change the number of satisfied clauses. Every clause is a bit mask over 2N literal positions, with a small weight attached. When a run is started, the block steps through the slots one per clock. For each clause it counts the literals that are true and, from that count, classifies the clause. A count of zero means the clause is unsatisfied. A count of exactly one means the clause rests on a single literal.

For every variable it accumulates a make value and a break value. The make value is the weight of unsatisfied clauses that flipping the variable would repair. The break value is the weight of single-support clauses that flipping it would spoil. Their difference is the gain. The block also reports which clauses are unsatisfied and whether the whole formula is satisfied. A local-search solver would load the formula once and then call a run after each flip to choose the next variable.

Top module: `clause_gain_eval`

## Requirements
- R1: Literal mask bit 2i stands for x_i and bit 2i+1 stands for NOT x_i (0-based). A clause whose mask is non-empty and has no true literal under the captured assignment sets its bit in `unsat` (bit j for slot j) at the end of a run. All other slots clear their bit.
- R2: A slot whose mask is all zero is vacant and never reports as unsatisfied. Reset empties every slot.
- R3: At the end of a run, `all_sat` is 1 exactly when `unsat` is all zero.
- R4: The make value of x_i, in field i of `make_val`, is the sum of the weights of the unsatisfied clauses that contain either literal of x_i.
- R5: The break value of x_i, in field i of `break_val`, is the sum of the weights of the clauses with exactly one true literal where that literal belongs to x_i.
- R6: Field i of `gain_val` is the two's-complement value of make minus break for x_i.
- R7: The weight written with a clause scales both its make and its break contribution, and rewriting a slot replaces its weight. With WEIGHTED=0 every clause counts as 1.
- R8: A load whose mask holds both literals of any one variable leaves the slot unchanged. It raises `load_err` for exactly the one cycle after the load edge. A valid load does not raise it.
- R9: A start accepted while idle raises `busy` on the next cycle. The single-cycle `done` pulse follows exactly M clock edges after the start edge, and results hold until the next accepted start.
- R10: The assignment is captured at the start edge. While a run is in progress, changes to `var_val`, further start pulses and loads have no effect.
- R11: After reset, `busy`, `done`, `load_err`, `unsat`, `make_val`, `break_val` and `gain_val` are zero, and `all_sat` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write a clause slot (honoured only while idle) |
| load_idx | input | IW | Slot to write |
| load_mask | input | 2*N | Literal mask of the clause |
| load_weight | input | WW | Clause weight |
| load_err | output | 1 | Pulse: last load was rejected |
| var_val | input | N | Variable assignment, bit i is x_i |
| start | input | 1 | Begin a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Pulse: results ready |
| unsat | output | M | Unsatisfied-clause vector |
| all_sat | output | 1 | No clause unsatisfied |
| make_val | output | N*SW | Per-variable make values, SW bits each |
| break_val | output | N*SW | Per-variable break values, SW bits each |
| gain_val | output | N*(SW+1) | Per-variable signed gains |

## Verification
The bench targets the corner cases that separate a correct evaluator from a nearly correct one. The first is a clause satisfied only through a negated literal: a design that attributes the break to the wrong variable, or gates it by the variable value rather than the literal value, shows a break on a variable that does not own the supporting literal. The second is vacant slots and a tautological load: a design that treats an empty mask as unsatisfied reports unsat bits on unused slots, and one that stores a rejected clause changes later results. The third is mid-run disturbances (assignment changes, a second start and a load during a run): a design that reads live inputs or accepts them gives mixed results or the wrong latency. The fourth is a weight rewrite: a design that keeps the old weight gives stale make values.

// File: rtl/cge_pkg.sv
package cge_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/cge_clause_store.sv
module cge_clause_store #(
    parameter int N  = 14,
    parameter int M  = 64,
    parameter int WW = 4,
    parameter int IW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [2*N-1:0]    wr_mask,
    input  logic [WW-1:0]     wr_weight,
    input  logic [IW-1:0]     rd_idx,
    output logic [2*N-1:0]    rd_mask,
    output logic [WW-1:0]     rd_weight,
    output logic              wr_reject
);
    typedef struct packed {
        logic [M-1:0][2*N-1:0] mask;
        logic [M-1:0][WW-1:0]  wt;
    } store_t;

    store_t s_d, s_q;
    logic [N-1:0] pair_both;

    // a clause naming a variable in both polarities is always true
    for (genvar i = 0; i < N; i++) begin : g_pair
        assign pair_both[i] = wr_mask[2*i] & wr_mask[2*i+1];
    end
    assign wr_reject = |pair_both;

    always_comb begin
        s_d = s_q;
        if (wr_en && !wr_reject) begin
            s_d.mask[wr_idx] = wr_mask;
            s_d.wt[wr_idx]   = wr_weight;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_mask   = s_q.mask[rd_idx];
    assign rd_weight = s_q.wt[rd_idx];
endmodule

// File: rtl/cge_clause_classify.sv
module cge_clause_classify #(
    parameter int N = 14
) (
    input  logic [2*N-1:0] mask,
    input  logic [N-1:0]   xv,
    output logic           is_unsat,
    output logic           is_single,
    output logic [N-1:0]   make_hit,
    output logic [N-1:0]   break_hit
);
    localparam int CW = $clog2(2*N+1);

    logic [2*N-1:0] lit;
    logic [2*N-1:0] tru;
    logic [CW-1:0]  cnt;

    for (genvar i = 0; i < N; i++) begin : g_lit
        assign lit[2*i]   = xv[i];
        assign lit[2*i+1] = ~xv[i];
    end
    assign tru = mask & lit;

    always_comb begin
        cnt = '0;
        for (int k = 0; k < 2*N; k++) cnt = cnt + CW'(tru[k]);
    end

    assign is_unsat  = (|mask) && (cnt == '0);
    assign is_single = (cnt == CW'(1));

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign make_hit[i]  = is_unsat  & (mask[2*i] | mask[2*i+1]);
        assign break_hit[i] = is_single & (tru[2*i]  | tru[2*i+1]);
    end
endmodule

// File: rtl/cge_gain_diff.sv
module cge_gain_diff #(
    parameter int N  = 14,
    parameter int SW = 11
) (
    input  logic [N*SW-1:0]     mk,
    input  logic [N*SW-1:0]     bk,
    output logic [N*(SW+1)-1:0] gain
);
    for (genvar i = 0; i < N; i++) begin : g_diff
        assign gain[i*(SW+1) +: SW+1] = {1'b0, mk[i*SW +: SW]} - {1'b0, bk[i*SW +: SW]};
    end
endmodule

// File: rtl/clause_gain_eval.sv
module clause_gain_eval #(
    parameter int N        = 14,
    parameter int M        = 64,
    parameter int WW       = 4,
    parameter bit WEIGHTED = 1'b1,
    localparam int IW      = (M > 1) ? $clog2(M) : 1,
    localparam int SW      = WW + $clog2(M + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [IW-1:0]       load_idx,
    input  logic [2*N-1:0]      load_mask,
    input  logic [WW-1:0]       load_weight,
    output logic                load_err,
    input  logic [N-1:0]        var_val,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic [M-1:0]        unsat,
    output logic                all_sat,
    output logic [N*SW-1:0]     make_val,
    output logic [N*SW-1:0]     break_val,
    output logic [N*(SW+1)-1:0] gain_val
);
    import cge_pkg::*;

    typedef struct packed {
        run_state_e            st;
        logic [IW-1:0]         idx;
        logic [N-1:0]          xv;
        logic [M-1:0]          unsat;
        logic                  all_sat;
        logic                  done;
        logic                  load_err;
        logic [N-1:0][SW-1:0]  mk;
        logic [N-1:0][SW-1:0]  bk;
    } regs_t;

    regs_t r_d, r_q;

    logic           idle;
    logic [2*N-1:0] rd_mask;
    logic [WW-1:0]  rd_weight;
    logic           wr_reject;
    logic           is_unsat, is_single;
    logic [N-1:0]   make_hit, break_hit;
    logic [WW-1:0]  w_eff;
    logic [SW-1:0]  w_ext;

    assign idle = (r_q.st == ST_IDLE);

    cge_clause_store #(.N(N), .M(M), .WW(WW), .IW(IW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (load_en & idle),
        .wr_idx    (load_idx),
        .wr_mask   (load_mask),
        .wr_weight (load_weight),
        .rd_idx    (r_q.idx),
        .rd_mask   (rd_mask),
        .rd_weight (rd_weight),
        .wr_reject (wr_reject)
    );

    cge_clause_classify #(.N(N)) u_class (
        .mask      (rd_mask),
        .xv        (r_q.xv),
        .is_unsat  (is_unsat),
        .is_single (is_single),
        .make_hit  (make_hit),
        .break_hit (break_hit)
    );

    assign w_eff = WEIGHTED ? rd_weight : WW'(1);
    assign w_ext = SW'(w_eff);

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.load_err = load_en && idle && wr_reject;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_RUN;
                    r_d.idx     = '0;
                    r_d.xv      = var_val;
                    r_d.unsat   = '0;
                    r_d.all_sat = 1'b0;
                    r_d.mk      = '0;
                    r_d.bk      = '0;
                end
            end
            ST_RUN: begin
                r_d.unsat[r_q.idx] = is_unsat;
                for (int i = 0; i < N; i++) begin
                    if (make_hit[i])  r_d.mk[i] = r_q.mk[i] + w_ext;
                    if (break_hit[i]) r_d.bk[i] = r_q.bk[i] + w_ext;
                end
                if (r_q.idx == IW'(M - 1)) begin
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.all_sat = (r_d.unsat == '0);
                end else begin
                    r_d.idx = r_q.idx + IW'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.all_sat <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    cge_gain_diff #(.N(N), .SW(SW)) u_diff (
        .mk   (r_q.mk),
        .bk   (r_q.bk),
        .gain (gain_val)
    );

    assign busy      = (r_q.st == ST_RUN);
    assign done      = r_q.done;
    assign load_err  = r_q.load_err;
    assign unsat     = r_q.unsat;
    assign all_sat   = r_q.all_sat;
    assign make_val  = r_q.mk;
    assign break_val = r_q.bk;
endmodule

// File: rtl/cge_checks.sv
module cge_checks #(
    parameter int N  = 14,
    parameter int M  = 64,
    parameter int SW = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            load_en,
    input logic            load_err,
    input logic            all_sat,
    input logic [M-1:0]    unsat,
    input logic [N*SW-1:0] make_val
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_start_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r8_err_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> $past(load_en));

    a_r4_no_make_if_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (done && all_sat) |-> (make_val == '0));

    a_r3_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (all_sat == (unsat == '0)));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(unsat));
endmodule

bind clause_gain_eval cge_checks #(.N(N), .M(M), .SW(SW)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .load_en  (load_en),
    .load_err (load_err),
    .all_sat  (all_sat),
    .unsat    (unsat),
    .make_val (make_val)
);

// File: tb/clause_gain_eval_test.sv
module clause_gain_eval_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int M  = 8;
    localparam int WW = 3;
    localparam int SW = WW + $clog2(M + 1);
    localparam int GW = SW + 1;

    // stimulus table: assignment {x3,x2,x1,x0}, expected unsat, make and break bytes per variable
    localparam int NV = 5;
    localparam logic [3:0]  TX [NV] = '{4'h0, 4'hF, 4'h5, 4'h6, 4'h8};
    localparam logic [7:0]  TU [NV] = '{8'h10, 8'h08, 8'h02, 8'h00, 8'h10};
    localparam logic [31:0] TM [NV] = '{32'h00010000, 32'h03000003, 32'h02000202,
                                        32'h00000000, 32'h00010000};
    localparam logic [31:0] TB [NV] = '{32'h00000102, 32'h00010100, 32'h04010000,
                                        32'h00020000, 32'h00010103};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_en = 1'b0;
    logic [2:0]      load_idx = '0;
    logic [7:0]      load_mask = '0;
    logic [WW-1:0]   load_weight = '0;
    logic            load_err;
    logic [N-1:0]    var_val = '0;
    logic            start = 1'b0;
    logic            busy, done, all_sat;
    logic [M-1:0]    unsat;
    logic [N*SW-1:0] make_val, break_val;
    logic [N*GW-1:0] gain_val;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clause_gain_eval #(.N(N), .M(M), .WW(WW), .WEIGHTED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_mask(load_mask), .load_weight(load_weight), .load_err(load_err),
        .var_val(var_val), .start(start), .busy(busy), .done(done),
        .unsat(unsat), .all_sat(all_sat), .make_val(make_val),
        .break_val(break_val), .gain_val(gain_val)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [7:0] mask, input logic [WW-1:0] w);
        @(negedge clk);
        load_en = 1'b1; load_idx = idx; load_mask = mask; load_weight = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run(input logic [3:0] xv, output int lat);
        @(negedge clk);
        var_val = xv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_out(input string tag, input logic [7:0] eu,
                             input logic [31:0] em, input logic [31:0] eb);
        chk({tag, " R1 unsat"}, unsat, eu);
        chk({tag, " R3 all_sat"}, all_sat, (eu == 8'h00));
        for (int v = 0; v < N; v++) begin
            chk({tag, " R4 make"},  make_val[v*SW +: SW],  em[8*v +: 8]);
            chk({tag, " R5 break"}, break_val[v*SW +: SW], eb[8*v +: 8]);
            chk({tag, " R6 gain"},  longint'($signed(gain_val[v*GW +: GW])),
                longint'(em[8*v +: 8]) - longint'(eb[8*v +: 8]));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 load_err", load_err, 0);
        chk("R11 unsat", unsat, 0);
        chk("R11 all_sat", all_sat, 1);
        chk("R11 make", make_val, 0);
        chk("R11 gain", gain_val, 0);
        rst_n = 1'b1;

        // R2 empty store: every slot vacant
        run(4'h0, lat);
        check_out("R2 empty", 8'h00, 32'h0, 32'h0);
        chk("R9 latency", lat, M);

        // formula: (x0|~x1|x2)w1 (~x0|x1|x3)w2 (x1|~x2|~x3)w1 (~x0|~x3)w3 (x2)w1
        load(3'd0, 8'h19, 3'd1);
        chk("R8 valid load no err", load_err, 0);
        load(3'd1, 8'h46, 3'd2);
        load(3'd2, 8'hA4, 3'd1);
        load(3'd3, 8'h82, 3'd3);
        load(3'd4, 8'h10, 3'd1);

        for (int k = 0; k < NV; k++) begin
            run(TX[k], lat);
            chk("R9 latency", lat, M);
            check_out($sformatf("vec%0d", k), TU[k], TM[k], TB[k]);
        end

        // R8 tautology (x1 | ~x1) into vacant slot 5 is rejected
        @(negedge clk);
        load_en = 1'b1; load_idx = 3'd5; load_mask = 8'h0C; load_weight = 3'd1;
        @(negedge clk);
        load_en = 1'b0;
        chk("R8 err pulse", load_err, 1);
        @(negedge clk);
        chk("R8 err one cycle", load_err, 0);
        run(TX[0], lat);
        check_out("R8 slot unchanged", TU[0], TM[0], TB[0]);

        // R10 disturbances during a run
        @(negedge clk);
        var_val = TX[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 0;
        chk("R9 busy", busy, 1);
        var_val = 4'hF;
        load_en = 1'b1; load_idx = 3'd6; load_mask = 8'h01; load_weight = 3'd1;
        @(negedge clk); lat++;
        load_en = 1'b0;
        chk("R10 busy load no err", load_err, 0);
        start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk("R10 restart ignored latency", lat, M);
        check_out("R10 live input ignored", TU[0], TM[0], TB[0]);
        @(negedge clk);
        chk("R9 results hold", unsat, TU[0]);
        run(TX[0], lat);
        check_out("R10 busy load ignored", TU[0], TM[0], TB[0]);

        // R7 weight rewrite on slot 3
        load(3'd3, 8'h82, 3'd1);
        run(4'hF, lat);
        check_out("R7 reweighted", 8'h08, 32'h01000001, 32'h00010100);

        // R11/R2 reset mid-life clears store and outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 unsat after reset", unsat, 0);
        chk("R11 all_sat after reset", all_sat, 1);
        chk("R11 break after reset", break_val, 0);
        rst_n = 1'b1;
        run(4'h0, lat);
        check_out("R2 store cleared", 8'h00, 32'h0, 32'h0);

        report();
    end
endmodule